// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the addressing layer of a slave device on a shared single-wire bus. The bit-level slot timing is handled elsewhere and arrives here as one-cycle strobes. A write slot carries the bit the master sent. A read slot asks the device for one bit. A bus-reset strobe marks the reset pulse and says whether the pulse had standard length.

After each bus reset, the block takes one 8-bit ROM command, least significant bit first. It then carries out that command against the 64-bit identity on `dev_id`:
- report the identity;
- compare it with the master's address;
- take part in a bitwise search arbitration;
- skip addressing;
- resume an earlier selection.

When the command completes successfully, `func_en` rises and the memory-function layer may take over the bus. A failed or unknown command makes the device deaf until the next bus reset.

The block also holds the bus speed. An overdrive skip or overdrive match switches the device to the higher speed. Only a standard-length reset pulse brings it back to standard speed.

Top module: `rom_cmd_layer`

## Requirements
- R1: After `rst`, `func_en`=0, `overdrive`=0, `rd_bit`=1 and the resume flag is clear. All slots are ignored until the first `bus_reset`.
- R2: After a `bus_reset`, the next 8 write slots form the command byte, least significant bit first. The default codes are: read 0x33, match 0x55, search 0xF0, skip 0xCC, resume 0xA5, overdrive skip 0x3C, overdrive match 0x69. A `bus_reset` in mid-byte restarts the byte.
- R3: Read command: the next 64 read slots return `dev_id` bit 0 first. After the 64th slot, `func_en` rises.
- R4: Match command: the next 64 write slots are compared with `dev_id`, bit 0 first. If all 64 agree, `func_en` rises. A single disagreement makes the device ignore every slot until the next `bus_reset`.
- R5: Search command: each of the 64 bits, starting at bit 0, takes three slots. A read slot returns the ID bit. A second read slot returns its complement. A write slot carries the master's choice. A choice that differs from the ID bit drops the device out, and it stays deaf until `bus_reset`. After the 64th bit, `func_en` rises.
- R6: Skip command: `func_en` rises right after the command byte.
- R7: The resume flag is set by a completed match or search, and cleared by a failed match or a search drop-out. Resume raises `func_en` when the flag is set; otherwise the device goes deaf.
- R8: Overdrive skip and overdrive match set `overdrive` when the command byte completes. Overdrive skip then acts as skip, and overdrive match acts as match.
- R9: A `bus_reset` with `reset_std`=1 clears `overdrive`. A `bus_reset` with `reset_std`=0 leaves it unchanged.
- R10: An unknown command code makes the device ignore all slots until the next `bus_reset`.
- R11: `func_en` stays low during the command byte and while an ID transfer is in progress. It falls on every `bus_reset`.
- R12: `rd_bit` is 1 in any read slot in which the device is not presenting an ID bit or its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse seen on the bus |
| reset_std | input | 1 | Qualifies `bus_reset`: pulse had standard length |
| wr_strobe | input | 1 | One-cycle strobe: master write slot |
| wr_bit | input | 1 | Bit value of the write slot |
| rd_strobe | input | 1 | One-cycle strobe: master read slot, consumes `rd_bit` |
| dev_id | input | 64 | Device identity, bit 0 sent first |
| rd_bit | output | 1 | Bit the device presents for the next read slot |
| func_en | output | 1 | Device selected; memory functions may follow |
| overdrive | output | 1 | 1 = higher bus speed |

## Verification
The hardest state to reach from the ports is a search drop-out, or a match failure, at an arbitrary bit position. Reaching it needs a long, exactly ordered run of slot triples before the divergence. The device must then stay silent for the rest of the transfer. The bench picks the divergence position with `$urandom` and mirrors the ID correctly up to that bit. It then inverts the master's choice and keeps issuing slots. Each later read must return 1, and `func_en` must stay low. A following resume must then be refused.

// File: rtl/rom_layer_pkg.sv
package rom_layer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_FUNC, ST_DEAF
  } rl_state_e;

  typedef enum logic [2:0] {
    OP_READ, OP_MATCH, OP_SEARCH, OP_SKIP, OP_RESUME, OP_ODSKIP, OP_ODMATCH, OP_BAD
  } rl_op_e;

  typedef enum logic [1:0] {
    PH_BIT, PH_INV, PH_CHOICE
  } rl_phase_e;
endpackage

// File: rtl/rl_cmd_decode.sv
module rl_cmd_decode
  import rom_layer_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] C_READ    = 8'h33,
  parameter logic [CMD_W-1:0] C_MATCH   = 8'h55,
  parameter logic [CMD_W-1:0] C_SEARCH  = 8'hF0,
  parameter logic [CMD_W-1:0] C_SKIP    = 8'hCC,
  parameter logic [CMD_W-1:0] C_RESUME  = 8'hA5,
  parameter logic [CMD_W-1:0] C_ODSKIP  = 8'h3C,
  parameter logic [CMD_W-1:0] C_ODMATCH = 8'h69
) (
  input  logic [CMD_W-1:0] code,
  output rl_op_e           op
);
  always_comb begin
    if      (code == C_READ)    op = OP_READ;
    else if (code == C_MATCH)   op = OP_MATCH;
    else if (code == C_SEARCH)  op = OP_SEARCH;
    else if (code == C_SKIP)    op = OP_SKIP;
    else if (code == C_RESUME)  op = OP_RESUME;
    else if (code == C_ODSKIP)  op = OP_ODSKIP;
    else if (code == C_ODMATCH) op = OP_ODMATCH;
    else                        op = OP_BAD;
  end
endmodule

// File: rtl/rl_id_pick.sv
module rl_id_pick #(
  parameter int ID_W  = 64,
  parameter int IDX_W = $clog2(ID_W)
) (
  input  logic [ID_W-1:0]  id,
  input  logic [IDX_W-1:0] idx,
  output logic             bit_o
);
  assign bit_o = id[idx];
endmodule

// File: rtl/rl_speed.sv
module rl_speed (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset,
  input  logic reset_std,
  input  logic go_fast,
  output logic overdrive
);
  always_ff @(posedge clk) begin
    if (rst)                          overdrive <= 1'b0;
    else if (bus_reset && reset_std)  overdrive <= 1'b0;
    else if (go_fast)                 overdrive <= 1'b1;
  end
endmodule

// File: rtl/rom_cmd_layer.sv
module rom_cmd_layer
  import rom_layer_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] C_READ    = 8'h33,
  parameter logic [CMD_W-1:0] C_MATCH   = 8'h55,
  parameter logic [CMD_W-1:0] C_SEARCH  = 8'hF0,
  parameter logic [CMD_W-1:0] C_SKIP    = 8'hCC,
  parameter logic [CMD_W-1:0] C_RESUME  = 8'hA5,
  parameter logic [CMD_W-1:0] C_ODSKIP  = 8'h3C,
  parameter logic [CMD_W-1:0] C_ODMATCH = 8'h69
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_reset,
  input  logic            reset_std,
  input  logic            wr_strobe,
  input  logic            wr_bit,
  input  logic            rd_strobe,
  input  logic [ID_W-1:0] dev_id,
  output logic            rd_bit,
  output logic            func_en,
  output logic            overdrive
);
  localparam int IDX_W = (ID_W > CMD_W) ? $clog2(ID_W) : $clog2(CMD_W);
  localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);
  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

  rl_state_e        state;
  rl_phase_e        phase;
  logic [IDX_W-1:0] cnt;
  logic [CMD_W-2:0] cmd_sr;
  logic             resume_q;
  logic             id_bit;
  logic             byte_done;
  logic             go_fast;
  rl_op_e           op;

  rl_cmd_decode #(
    .CMD_W(CMD_W), .C_READ(C_READ), .C_MATCH(C_MATCH), .C_SEARCH(C_SEARCH),
    .C_SKIP(C_SKIP), .C_RESUME(C_RESUME), .C_ODSKIP(C_ODSKIP), .C_ODMATCH(C_ODMATCH)
  ) u_dec (
    .code ({wr_bit, cmd_sr}),
    .op   (op)
  );

  rl_id_pick #(.ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
    .id    (dev_id),
    .idx   (cnt),
    .bit_o (id_bit)
  );

  assign byte_done = !bus_reset && (state == ST_CMD) && wr_strobe && (cnt == CMD_LAST);
  assign go_fast   = byte_done && ((op == OP_ODSKIP) || (op == OP_ODMATCH));

  rl_speed u_speed (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset),
    .reset_std (reset_std),
    .go_fast   (go_fast),
    .overdrive (overdrive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_BIT;
      cnt      <= '0;
      cmd_sr   <= '0;
      resume_q <= 1'b0;
    end else if (bus_reset) begin
      state <= ST_CMD;
      phase <= PH_BIT;
      cnt   <= '0;
    end else begin
      case (state)
        ST_CMD: if (wr_strobe) begin
          cmd_sr <= {wr_bit, cmd_sr[CMD_W-2:1]};
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            case (op)
              OP_READ:                state <= ST_READ;
              OP_MATCH, OP_ODMATCH:   state <= ST_MATCH;
              OP_SEARCH:              state <= ST_SEARCH;
              OP_SKIP, OP_ODSKIP:     state <= ST_FUNC;
              OP_RESUME:              state <= resume_q ? ST_FUNC : ST_DEAF;
              default:                state <= ST_DEAF;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: if (rd_strobe) begin
          if (cnt == ID_LAST) state <= ST_FUNC;
          else                cnt   <= cnt + 1'b1;
        end
        ST_MATCH: if (wr_strobe) begin
          if (wr_bit != id_bit) begin
            state    <= ST_DEAF;
            resume_q <= 1'b0;
          end else if (cnt == ID_LAST) begin
            state    <= ST_FUNC;
            resume_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEARCH: begin
          case (phase)
            PH_BIT:  if (rd_strobe) phase <= PH_INV;
            PH_INV:  if (rd_strobe) phase <= PH_CHOICE;
            default: if (wr_strobe) begin
              phase <= PH_BIT;
              if (wr_bit != id_bit) begin
                state    <= ST_DEAF;
                resume_q <= 1'b0;
              end else if (cnt == ID_LAST) begin
                state    <= ST_FUNC;
                resume_q <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_bit <= 1'b1;
    else begin
      case (state)
        ST_READ:   rd_bit <= id_bit;
        ST_SEARCH: rd_bit <= (phase == PH_BIT) ? id_bit :
                             (phase == PH_INV) ? ~id_bit : 1'b1;
        default:   rd_bit <= 1'b1;
      endcase
    end
  end

  assign func_en = (state == ST_FUNC);
endmodule

// File: rtl/rom_cmd_layer_chk.sv
module rom_cmd_layer_chk (
  input logic clk,
  input logic rst,
  input logic bus_reset,
  input logic reset_std,
  input logic wr_strobe,
  input logic rd_strobe,
  input logic rd_bit,
  input logic func_en,
  input logic overdrive
);
  // R11
  func_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !func_en);

  // R9
  std_reset_slow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && reset_std) |=> !overdrive);

  // R9
  short_reset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && !reset_std) |=> (overdrive == $past(overdrive)));

  // R8
  fast_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overdrive) |-> $past(wr_strobe));

  // R11
  func_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(func_en) |-> $past(wr_strobe || rd_strobe));

  // R12
  idle_read_high_chk: assert property (@(posedge clk) disable iff (rst)
    (func_en && $past(func_en)) |-> rd_bit);
endmodule

bind rom_cmd_layer rom_cmd_layer_chk u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .reset_std(reset_std),
  .wr_strobe(wr_strobe), .rd_strobe(rd_strobe), .rd_bit(rd_bit),
  .func_en(func_en), .overdrive(overdrive)
);

// File: tb/rom_cmd_layer_test.sv
module rom_cmd_layer_test;
  localparam logic [7:0] K_READ = 8'h33, K_MATCH = 8'h55, K_SEARCH = 8'hF0,
    K_SKIP = 8'hCC, K_RESUME = 8'hA5, K_ODSKIP = 8'h3C, K_ODMATCH = 8'h69;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset = 1'b0, reset_std = 1'b1;
  logic wr_strobe = 1'b0, wr_bit = 1'b0, rd_strobe = 1'b0;
  logic [63:0] dev_id = 64'h0123_4567_89AB_CDEF;
  logic rd_bit, func_en, overdrive;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  rom_cmd_layer uut (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .reset_std(reset_std),
    .wr_strobe(wr_strobe), .wr_bit(wr_bit), .rd_strobe(rd_strobe),
    .dev_id(dev_id), .rd_bit(rd_bit), .func_en(func_en), .overdrive(overdrive)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busrst(input logic std);
    @(negedge clk); bus_reset = 1'b1; reset_std = std;
    @(negedge clk); bus_reset = 1'b0;
    idle(2);
  endtask

  task automatic wslot(input logic b);
    @(negedge clk); wr_strobe = 1'b1; wr_bit = b;
    @(negedge clk); wr_strobe = 1'b0;
    idle(2);
  endtask

  task automatic rslot(output logic b);
    @(negedge clk); b = rd_bit; rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
    idle(2);
  endtask

  task automatic send_byte(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wslot(c[i]);
  endtask

  task automatic read_n(input int n, output logic [63:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < n; i++) begin rslot(b); v[i] = b; end
  endtask

  function automatic logic [63:0] ones(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  // expected selection after a match with an optional flipped bit
  function automatic logic exp_match_sel(input int flip);
    return flip < 0;
  endfunction

  task automatic do_match(input logic [7:0] code, input int flip);
    send_byte(code);
    for (int i = 0; i < 64; i++) wslot((i == flip) ? ~dev_id[i] : dev_id[i]);
  endtask

  initial begin
    logic [63:0] v;
    logic a, b;
    int errs, k;
    void'($urandom(32'd2718));
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 func_en", func_en, 0);
    chk("R1 overdrive", overdrive, 0);
    chk("R1 rd_bit", rd_bit, 1);
    send_byte(K_READ);
    read_n(8, v);
    chk("R1 slots before bus reset ignored", v, ones(8));
    chk("R1 func_en before bus reset", func_en, 0);

    // R3 read command on several IDs (R2 byte order)
    for (int t = 0; t < 3; t++) begin
      dev_id = {$urandom, $urandom};
      busrst(1);
      send_byte(K_READ);
      chk("R11 func_en after read byte", func_en, 0);
      read_n(32, v);
      chk("R11 func_en mid transfer", func_en, 0);
      read_n(32, v);
      chk("R3 low half rd", v[31:0], dev_id[63:32]);
      chk("R3/R11 func_en after read", func_en, 1);
      read_n(1, v);
      chk("R12 read after selection", v[0], 1);
    end

    // R2 reset mid-byte restarts byte
    busrst(1);
    for (int i = 0; i < 4; i++) wslot(1'b0);
    busrst(1);
    send_byte(K_SKIP);
    chk("R2 mid-byte reset restart", func_en, 1);

    // R4 good match then R7 resume
    busrst(1);
    do_match(K_MATCH, -1);
    chk("R4 match selects", func_en, exp_match_sel(-1));
    busrst(1);
    send_byte(K_RESUME);
    chk("R7 resume after match", func_en, 1);

    // R4 failed match at random bit; R7 flag cleared
    for (int t = 0; t < 3; t++) begin
      k = $urandom_range(63, 0);
      busrst(1);
      do_match(K_MATCH, k);
      chk("R4 mismatch deselects", func_en, exp_match_sel(k));
      send_byte(K_SKIP);
      chk("R4 deaf after mismatch", func_en, 0);
      busrst(1);
      send_byte(K_RESUME);
      chk("R7 resume refused", func_en, 0);
      read_n(4, v);
      chk("R7/R12 deaf reads", v, ones(4));
    end

    // R5 full search
    busrst(1);
    send_byte(K_SEARCH);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      rslot(a); rslot(b);
      if (a !== dev_id[i] || b !== ~dev_id[i]) errs++;
      wslot(dev_id[i]);
    end
    chk("R5 search bit/complement errors", errs, 0);
    chk("R5 search selects", func_en, 1);
    busrst(1);
    send_byte(K_RESUME);
    chk("R7 resume after search", func_en, 1);

    // R5 search drop-out at random bit
    k = $urandom_range(62, 0);
    busrst(1);
    send_byte(K_SEARCH);
    for (int i = 0; i <= k; i++) begin
      rslot(a); rslot(b);
      wslot((i == k) ? ~dev_id[i] : dev_id[i]);
    end
    rslot(a); rslot(b);
    chk("R5/R12 silent after drop-out", {a, b}, 2'b11);
    chk("R5 not selected after drop-out", func_en, 0);
    busrst(1);
    send_byte(K_RESUME);
    chk("R7 resume refused after drop-out", func_en, 0);

    // R6 skip
    busrst(1);
    send_byte(K_SKIP);
    chk("R6 skip selects", func_en, 1);
    chk("R6 skip keeps speed", overdrive, 0);

    // R10 unknown code
    busrst(1);
    send_byte(8'h00);
    send_byte(K_READ);
    read_n(8, v);
    chk("R10 unknown code deaf", v, ones(8));
    chk("R10 not selected", func_en, 0);

    // R8 / R9 overdrive
    busrst(1);
    send_byte(K_ODSKIP);
    chk("R8 overdrive skip speed", overdrive, 1);
    chk("R8 overdrive skip selects", func_en, 1);
    busrst(0);
    chk("R9 short reset keeps speed", overdrive, 1);
    chk("R11 func_en drops on reset", func_en, 0);
    busrst(1);
    chk("R9 standard reset slows", overdrive, 0);
    busrst(1);
    send_byte(K_ODMATCH);
    chk("R8 overdrive match speed after byte", overdrive, 1);
    chk("R8 overdrive match not yet selected", func_en, 0);
    for (int i = 0; i < 64; i++) wslot(dev_id[i]);
    chk("R8 overdrive match selects", func_en, 1);
    busrst(1);
    chk("R9 standard reset after od match", overdrive, 0);

    // random mix of match / skip / read
    for (int t = 0; t < 10; t++) begin
      int sel;
      sel = $urandom_range(2, 0);
      busrst(1);
      if (sel == 0) begin
        k = ($urandom_range(1, 0) == 1) ? $urandom_range(63, 0) : -1;
        do_match(K_MATCH, k);
        chk("R4 random match", func_en, exp_match_sel(k));
      end else if (sel == 1) begin
        send_byte(K_SKIP);
        chk("R6 random skip", func_en, 1);
      end else begin
        send_byte(K_READ);
        read_n(64, v);
        chk("R3 random read", v, dev_id);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule